// File: doc/BRIEF.md
# Dual-Mode Watchdog and Interval Timer

This block is a 32-bit down-counter attached to a plain register bus: a byte address, a write strobe, write data and read data that follows the address with no wait state. It runs in one of two modes. As an interval timer, it sets an event flag when it expires. That flag can drive an interrupt line, and the counter can reload itself from a stored start value. As a watchdog, it emits a one-cycle reset request on expiry and records the reset in a sticky flag. Software can read that flag after the system has come back up.

An 8-bit divider sets the decrement rate. Once watchdog mode is entered, it cannot be left through the control register. The only way out is a two-word unlock sequence written to a dedicated unlock register. A stray write to control therefore cannot disarm the watchdog.

Top module: `dual_wdt_timer`

## Requirements
- R1: After reset, every register reads 0, and `irq_o` and `rst_req_o` are low. Registers sit at these byte addresses: start value 0x00 (read/write), live count 0x04 (read-only, writes ignored), control 0x08, event flag 0x0C, reset flag 0x10, unlock 0x14 (reads 0). Control bit fields are: divider in bits 15:8, watchdog mode in bit 3, interrupt enable in bit 2, auto-reload in bit 1, run in bit 0. Each flag register holds its flag in bit 0.
- R2: A write to the start value also loads the live count and restarts the divider. A write to control also restarts the divider. While run is 1, the count drops by one every (divider + 1) clock edges. While run is 0, the count holds.
- R3: Expiry is the step of the count from 1 to 0. In timer mode, expiry sets the event flag on that same edge. A count that is already 0 never expires.
- R4: On expiry in timer mode with auto-reload set, the count takes the start value instead of 0. In every other case the count stays at 0.
- R5: `irq_o` is high exactly when the event flag, interrupt enable and timer mode are all true.
- R6: Writing 1 to bit 0 of a flag register clears that flag. If an expiry falls on the same edge as the clearing write, the flag stays set.
- R7: On expiry in watchdog mode, `rst_req_o` is high for exactly the one cycle after the expiry edge. The reset flag sets on that edge and stays set. The event flag is not touched.
- R8: Writing 1 to control bit 3 enters watchdog mode at any time. Writing 0 to control bit 3 does not leave watchdog mode.
- R9: Watchdog mode is left only by two consecutive unlock-register writes: 0x12345678, then 0x87654321. A write of any other value, or the two values in the wrong order, sends the sequence back to its first step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Register byte address |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| irq_o | output | 1 | Timer interrupt |
| rst_req_o | output | 1 | Watchdog reset request, one-cycle pulse |

## Verification
The event flag can be set by an expiry and cleared by a bus write on the same edge. The bench provokes this collision with a start value of 1 and a divider of 0, so the expiry lands exactly on the next write, which is the clearing write. It judges the outcome by reading the flag as still set, then clearing it with a second write that does go through. Around this directed case, random divider, start-value and wait combinations check the count against a computed value and check that the flag sets on the predicted edge and not one edge earlier.

// File: rtl/dwt_pkg.sv
package dwt_pkg;
  localparam int DW = 32;

  localparam logic [7:0] OFS_START = 8'h00;
  localparam logic [7:0] OFS_COUNT = 8'h04;
  localparam logic [7:0] OFS_CTRL  = 8'h08;
  localparam logic [7:0] OFS_EVT   = 8'h0C;
  localparam logic [7:0] OFS_RSTF  = 8'h10;
  localparam logic [7:0] OFS_UNLK  = 8'h14;

  localparam logic [DW-1:0] KEY_FIRST  = 32'h1234_5678;
  localparam logic [DW-1:0] KEY_SECOND = 32'h8765_4321;

  localparam int B_RUN = 0;
  localparam int B_ARL = 1;
  localparam int B_IEN = 2;
  localparam int B_WD  = 3;
  localparam int B_DIV = 8;
endpackage

// File: rtl/dwt_prescaler.sv
module dwt_prescaler #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] pcnt_q;

  assign tick_o = run_i && !restart_i && (pcnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 pcnt_q <= '0;
    else if (!run_i || restart_i) pcnt_q <= '0;
    else if (tick_o)             pcnt_q <= '0;
    else                         pcnt_q <= pcnt_q + 1'b1;
  end

  // R2: with a non-zero divider, two ticks never fall on adjacent edges
  p_tick_gap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && div_i != '0) |=> !tick_o);
endmodule

// File: rtl/dwt_unlock.sv
module dwt_unlock
  import dwt_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] data_i,
  output logic          clear_o
);
  logic armed_q;

  assign clear_o = wr_i && armed_q && (data_i == KEY_SECOND);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   armed_q <= 1'b0;
    else if (wr_i) armed_q <= (data_i == KEY_FIRST);
  end

  // R9: the second key alone, with no first key before it, never unlocks
  p_no_lone_key_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && data_i != KEY_FIRST) |=> !clear_o || $past(data_i) == KEY_FIRST);
endmodule

// File: rtl/dwt_counter.sv
module dwt_counter #(
  parameter int CW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  input  logic          tick_i,
  input  logic          reload_i,
  input  logic [CW-1:0] reload_val_i,
  output logic [CW-1:0] cnt_o,
  output logic          expire_o
);
  logic [CW-1:0] cnt_q;
  localparam logic [CW-1:0] ONE = CW'(1);

  assign cnt_o    = cnt_q;
  assign expire_o = tick_i && !load_i && (cnt_q == ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (load_i)                   cnt_q <= load_val_i;
    else if (tick_i && cnt_q != '0) begin
      if (cnt_q == ONE && reload_i)    cnt_q <= reload_val_i;
      else                             cnt_q <= cnt_q - ONE;
    end
  end

  // R2: count holds without a tick or a load
  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !load_i) |=> $stable(cnt_q));
  // R2: a tick above one steps the count down by one
  p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load_i && cnt_q > ONE) |=> cnt_q == $past(cnt_q) - ONE);
  // R4: without reload, expiry leaves the count at zero
  p_stop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_o && !reload_i) |=> cnt_q == '0);
endmodule

// File: rtl/dual_wdt_timer.sv
module dual_wdt_timer
  import dwt_pkg::*;
#(
  parameter int AW    = 8,
  parameter int DIV_W = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o,
  output logic          rst_req_o
);
  logic [DW-1:0]    start_q;
  logic [DIV_W-1:0] div_q;
  logic             run_q, arl_q, ien_q, wd_q;
  logic             evt_q, rstf_q, req_q;

  logic wr_start, wr_ctrl, wr_evt, wr_rstf, wr_unlk;
  logic tick, expire, unlock_clr;
  logic [DW-1:0] cnt;

  assign wr_start = we_i && (addr_i == AW'(OFS_START));
  assign wr_ctrl  = we_i && (addr_i == AW'(OFS_CTRL));
  assign wr_evt   = we_i && (addr_i == AW'(OFS_EVT));
  assign wr_rstf  = we_i && (addr_i == AW'(OFS_RSTF));
  assign wr_unlk  = we_i && (addr_i == AW'(OFS_UNLK));

  dwt_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk_i, .rst_ni,
    .run_i     (run_q),
    .restart_i (wr_start || wr_ctrl),
    .div_i     (div_q),
    .tick_o    (tick)
  );

  dwt_counter #(.CW(DW)) u_cnt (
    .clk_i, .rst_ni,
    .load_i       (wr_start),
    .load_val_i   (wdata_i),
    .tick_i       (tick),
    .reload_i     (arl_q && !wd_q),
    .reload_val_i (start_q),
    .cnt_o        (cnt),
    .expire_o     (expire)
  );

  dwt_unlock u_unlk (
    .clk_i, .rst_ni,
    .wr_i    (wr_unlk),
    .data_i  (wdata_i),
    .clear_o (unlock_clr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= '0;
      div_q   <= '0;
      run_q   <= 1'b0;
      arl_q   <= 1'b0;
      ien_q   <= 1'b0;
      wd_q    <= 1'b0;
      evt_q   <= 1'b0;
      rstf_q  <= 1'b0;
      req_q   <= 1'b0;
    end else begin
      if (wr_start) start_q <= wdata_i;
      if (wr_ctrl) begin
        div_q <= wdata_i[B_DIV +: DIV_W];
        run_q <= wdata_i[B_RUN];
        arl_q <= wdata_i[B_ARL];
        ien_q <= wdata_i[B_IEN];
      end
      // watchdog bit: set by control, cleared only by unlock
      if (wr_ctrl && wdata_i[B_WD]) wd_q <= 1'b1;
      else if (unlock_clr)          wd_q <= 1'b0;
      // expiry wins over a same-edge clear
      if (expire && !wd_q)            evt_q <= 1'b1;
      else if (wr_evt && wdata_i[0])  evt_q <= 1'b0;
      if (expire && wd_q)             rstf_q <= 1'b1;
      else if (wr_rstf && wdata_i[0]) rstf_q <= 1'b0;
      req_q <= expire && wd_q;
    end
  end

  assign irq_o     = evt_q && ien_q && !wd_q;
  assign rst_req_o = req_q;

  always_comb begin
    rdata_o = '0;
    if (addr_i == AW'(OFS_START))      rdata_o = start_q;
    else if (addr_i == AW'(OFS_COUNT)) rdata_o = cnt;
    else if (addr_i == AW'(OFS_CTRL)) begin
      rdata_o[B_DIV +: DIV_W] = div_q;
      rdata_o[B_WD]  = wd_q;
      rdata_o[B_IEN] = ien_q;
      rdata_o[B_ARL] = arl_q;
      rdata_o[B_RUN] = run_q;
    end
    else if (addr_i == AW'(OFS_EVT))   rdata_o[0] = evt_q;
    else if (addr_i == AW'(OFS_RSTF))  rdata_o[0] = rstf_q;
  end

  // R7: reset request lasts one cycle
  p_req_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o);
  // R7: reset request is always accompanied by the sticky flag
  p_req_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> rstf_q);
  // R8: watchdog mode survives everything but the unlock
  p_wd_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wd_q && !unlock_clr) |=> wd_q);
  // R6: event flag only drops through a clearing write
  p_evt_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_q && !(wr_evt && wdata_i[0])) |=> evt_q);
  // R3: a timer-mode expiry always leaves the event flag set
  p_evt_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire && !wd_q) |=> evt_q);
endmodule

// File: tb/dual_wdt_timer_tb.sv
module dual_wdt_timer_tb;
  localparam logic [7:0] A_START = 8'h00, A_COUNT = 8'h04, A_CTRL = 8'h08,
                         A_EVT = 8'h0C, A_RSTF = 8'h10, A_UNLK = 8'h14;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, rst_req;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  dual_wdt_timer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .rst_req_o(rst_req)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog expired act=%0d exp<=100000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  function automatic int exp_edges(int n, int p);
    return n * (p + 1);
  endfunction

  function automatic int exp_count(int n, int p, int k);
    return n - k / (p + 1);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] v);
    addr = a; we = 1'b0;
    #1 v = rdata;
  endtask

  task automatic wait_edges(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start(logic [31:0] ctrl, logic [31:0] n);
    wr(A_CTRL, ctrl & ~32'h1);
    wr(A_START, n);
    wr(A_CTRL, ctrl);
  endtask

  initial begin
    logic [31:0] v;
    void'($urandom(32'd1234));
    wait_edges(3);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(A_CTRL, v);  chk("R1 ctrl reset", v, 32'h0);
    rd(A_COUNT, v); chk("R1 count reset", v, 32'h0);
    rd(A_EVT, v);   chk("R1 evt reset", v, 32'h0);
    chk("R1 irq reset", {31'b0, irq}, 32'h0);
    chk("R1 req reset", {31'b0, rst_req}, 32'h0);

    // R1 readback, R2 load and hold while stopped
    wr(A_START, 32'h55);
    rd(A_START, v); chk("R1 start readback", v, 32'h55);
    rd(A_COUNT, v); chk("R2 count loaded", v, 32'h55);
    wr(A_CTRL, 32'h0000_0306);
    rd(A_CTRL, v);  chk("R1 ctrl readback", v, 32'h0000_0306);
    wr(A_COUNT, 32'h9);
    wait_edges(10);
    rd(A_COUNT, v); chk("R2 hold when stopped", v, 32'h55);
    rd(A_UNLK, v);  chk("R1 unlock reads zero", v, 32'h0);

    // R2/R3/R4 random divider and start value
    for (int it = 0; it < 8; it++) begin
      int p, n, k, tot;
      p = $urandom % 4;
      n = 1 + $urandom % 12;
      tot = exp_edges(n, p);
      k = $urandom % tot;
      start(32'(p << 8) | 32'h1, 32'(n));
      wait_edges(k);
      rd(A_COUNT, v); chk("R2 count rate", v, 32'(exp_count(n, p, k)));
      wait_edges(tot - k - 1);
      rd(A_COUNT, v); chk("R2 count one before expiry", v, 32'h1);
      rd(A_EVT, v);   chk("R3 no early event", v, 32'h0);
      wait_edges(1);
      rd(A_EVT, v);   chk("R3 event on expiry", v, 32'h1);
      rd(A_COUNT, v); chk("R4 stays zero", v, 32'h0);
      chk("R5 no irq when disabled", {31'b0, irq}, 32'h0);
      wr(A_EVT, 32'h1);
      rd(A_EVT, v);   chk("R6 event cleared", v, 32'h0);
    end

    // R3 count already zero never expires
    wait_edges(20);
    rd(A_EVT, v); chk("R3 zero count no event", v, 32'h0);

    // R4/R5 auto-reload with interrupt
    start(32'h0000_0107, 32'd3);
    wait_edges(5);
    chk("R5 irq low before expiry", {31'b0, irq}, 32'h0);
    wait_edges(1);
    rd(A_EVT, v);   chk("R3 reload event", v, 32'h1);
    chk("R5 irq on event", {31'b0, irq}, 32'h1);
    rd(A_COUNT, v); chk("R4 reloaded", v, 32'd3);
    wr(A_CTRL, 32'h0000_0103);
    chk("R5 irq masked", {31'b0, irq}, 32'h0);
    wr(A_EVT, 32'h1);
    rd(A_EVT, v);   chk("R6 event cleared after reload", v, 32'h0);
    wr(A_CTRL, 32'h0);

    // R6 collision: expiry on the clearing edge
    start(32'h0000_0001, 32'd1);
    wr(A_EVT, 32'h1);
    rd(A_EVT, v); chk("R6 set wins over clear", v, 32'h1);
    wr(A_EVT, 32'h1);
    rd(A_EVT, v); chk("R6 second clear", v, 32'h0);

    // R7 watchdog expiry
    start(32'h0000_0209, 32'd2);
    wait_edges(5);
    chk("R7 no early request", {31'b0, rst_req}, 32'h0);
    wait_edges(1);
    chk("R7 request pulse", {31'b0, rst_req}, 32'h1);
    rd(A_RSTF, v); chk("R7 reset flag set", v, 32'h1);
    rd(A_EVT, v);  chk("R7 event untouched", v, 32'h0);
    chk("R5 no irq in watchdog", {31'b0, irq}, 32'h0);
    wait_edges(1);
    chk("R7 request one cycle", {31'b0, rst_req}, 32'h0);
    rd(A_RSTF, v); chk("R7 reset flag held", v, 32'h1);
    rd(A_COUNT, v); chk("R4 watchdog stays zero", v, 32'h0);

    // R8 sticky watchdog bit
    wr(A_CTRL, 32'h0);
    rd(A_CTRL, v); chk("R8 zero write ignored", v, 32'h8);
    wr(A_RSTF, 32'h1);
    rd(A_RSTF, v); chk("R6 reset flag cleared", v, 32'h0);

    // R9 unlock sequence
    wr(A_UNLK, 32'h8765_4321);
    rd(A_CTRL, v); chk("R9 second key alone", v, 32'h8);
    wr(A_UNLK, 32'h1234_5678);
    wr(A_UNLK, 32'hDEAD_BEEF);
    wr(A_UNLK, 32'h8765_4321);
    rd(A_CTRL, v); chk("R9 broken sequence", v, 32'h8);
    wr(A_UNLK, 32'h1234_5678);
    wr(A_UNLK, 32'h8765_4321);
    rd(A_CTRL, v); chk("R9 unlocked", v, 32'h0);
    wr(A_CTRL, 32'h8);
    rd(A_CTRL, v); chk("R8 set any time", v, 32'h8);
    wr(A_UNLK, 32'h1234_5678);
    wr(A_UNLK, 32'h8765_4321);
    rd(A_CTRL, v); chk("R9 unlocked again", v, 32'h0);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule